// File: doc/BRIEF.md
# Binary64 / Binary32 Format Converter

This block converts a floating-point value between the 64-bit and 32-bit IEEE-754 binary interchange formats. A single select input chooses the direction for each transaction. Narrowing (64 to 32 bits) rounds to nearest with ties to even. Results too large become a signed infinity, and results too small become a correctly rounded subnormal or a signed zero. Widening (32 to 64 bits) is always exact. It turns 32-bit subnormals into normal 64-bit values. Both directions return any NaN in quiet form.

A transaction is presented by raising `inValid` together with `opSel` and `dataIn`. The result appears on `dataOut` one clock later, qualified by `outValid`. A new transaction may be issued on every cycle. While no transaction is presented, `dataOut` keeps the last result.

Top module: `fpFormatConv`

## Requirements
- R1: `outValid` is low during and after reset until a transaction arrives. It equals the value `inValid` had on the previous rising edge.
- R2: When `inValid` is low at a rising edge, `dataOut` keeps its previous value (0 after reset).
- R3: With `opSel`=0, `dataIn[63:0]` is read as binary64. The binary32 result is placed in `dataOut[31:0]` and `dataOut[63:32]` is zero. Finite values are rounded to nearest. An exact halfway case goes to the neighbour whose lowest fraction bit is 0.
- R4: When narrowing, a finite value whose rounded magnitude reaches 2^128 becomes infinity with the input sign (0x7F800000 or 0xFF800000). 0x47EFFFFFEFFFFFFF still gives 0x7F7FFFFF. 0x47EFFFFFF0000000 overflows.
- R5: When narrowing, values below the binary32 normal range are rounded to a subnormal, with all discarded bits taken into account. 2^-149 gives 0x00000001. 2^-150 gives a signed zero. 1.5×2^-150 gives 0x00000001. Binary64 subnormals give a signed zero.
- R6: When narrowing, infinity keeps its sign. A NaN gives sign | 0x7FC00000 | fraction bits 50..29 placed in result bits 21..0.
- R7: With `opSel`=1, `dataIn[31:0]` is read as binary32. A normal value widens exactly: the exponent is rebiased by +0x380 and the fraction is placed in the top 23 fraction bits.
- R8: When widening, a binary32 subnormal becomes a normal binary64 value of equal magnitude. 0x00000001 gives 0x36A0000000000000.
- R9: When widening, a NaN gives sign | 0x7FF8000000000000 with fraction bits 21..0 at binary64 fraction bits 50..29. Infinity keeps its sign. Zero keeps its sign.
- R10: Widening any non-NaN binary32 value and then narrowing the result returns the original 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Transaction present on this cycle |
| opSel | input | 1 | 0 narrows 64 to 32 bits, 1 widens 32 to 64 bits |
| dataIn | input | 64 | Operand; widening uses bits 31..0 |
| outValid | output | 1 | Result on `dataOut` is new this cycle |
| dataOut | output | 64 | Converted value |

## Verification
Directed narrowing values cover three rounding cases near 1.0: exactly halfway, halfway plus one unit, and halfway with an odd neighbour. Together they separate ties-to-even from plain round-half-up and from truncation.

Values at the largest finite magnitude and one half-unit above it locate the overflow threshold. Values at 2^-149, 2^-150, 1.5×2^-150 and binary64 subnormals check the sticky logic on the subnormal path.

Pseudo-random binary64 operands, some with exponents steered into the underflow band, are compared against a model built on integer significand arithmetic. Pseudo-random binary32 operands, every fourth one forced subnormal, are widened and then narrowed back. Only an exact bit match passes, which exposes any loss in normalization or rebiasing.

// File: rtl/fpConvPkg.sv
package fpConvPkg;
  localparam int WideW     = 64;
  localparam int NarrowW   = 32;
  localparam int WideExpW  = 11;
  localparam int WideFracW = 52;
  localparam int NarExpW   = 8;
  localparam int NarFracW  = 23;
  localparam int GuardW    = 7;
  localparam int FracShift = WideFracW - NarFracW;            // 29
  localparam int JamShift  = FracShift - GuardW;              // 22
  localparam int RoundExpBias = 897;                          // 1023 - 127 + 1
  localparam int RoundExpMax  = 253;
  localparam logic [WideExpW-1:0] WideExpAll = '1;
  localparam logic [NarExpW-1:0]  NarExpAll  = '1;

  typedef struct packed {
    logic capture;
    logic markValid;
  } ctrlStrobeT;
endpackage

// File: rtl/fpConvCtrl.sv
module fpConvCtrl
  import fpConvPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctrlStrobeT strobes,
  output logic       outValid
);
  always_comb begin
    strobes.capture   = inValid;
    strobes.markValid = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.markValid;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/fpConvDatapath.sv
module fpConvDatapath
  import fpConvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic              opSel,
  input  logic [WideW-1:0]  dataIn,
  output logic [WideW-1:0]  dataOut
);
  // ---------------- narrowing path ----------------
  logic                 nSign;
  logic [WideExpW-1:0]  nExp;
  logic [WideFracW-1:0] nFrac;
  logic [NarrowW-1:0]   sig;
  logic signed [12:0]   rExp;
  logic [12:0]          negAmt;
  logic [GuardW-1:0]    roundBits;
  logic [24:0]          rounded;
  logic [NarrowW-1:0]   narrowRes;

  always_comb begin
    nSign = dataIn[WideW-1];
    nExp  = dataIn[WideW-2 -: WideExpW];
    nFrac = dataIn[WideFracW-1:0];
    sig   = {1'b0, (nExp != '0), nFrac[WideFracW-1:JamShift]};
    sig[0] = nFrac[JamShift] | (|nFrac[JamShift-1:0]);
    rExp  = $signed({2'b00, nExp}) - 13'sd897;
    negAmt = '0;
    roundBits = '0;
    rounded = '0;
    if (nExp == WideExpAll) begin
      if (nFrac != '0) narrowRes = {nSign, NarExpAll, 1'b1, nFrac[WideFracW-2 -: 22]};
      else             narrowRes = {nSign, NarExpAll, {NarFracW{1'b0}}};
    end else if (rExp > 13'sd253 || (rExp == 13'sd253 && sig >= 32'h7FFF_FFC0)) begin
      narrowRes = {nSign, NarExpAll, {NarFracW{1'b0}}};
    end else begin
      if (rExp < 0) begin
        negAmt = 13'(-rExp);
        if (negAmt >= 13'd32) sig = {31'b0, |sig};
        else sig = (sig >> negAmt[4:0]) |
                   {31'b0, |(sig & ((32'h1 << negAmt[4:0]) - 32'h1))};
        rExp = '0;
      end
      roundBits = sig[GuardW-1:0];
      rounded   = 25'((sig + 32'h40) >> GuardW);
      if (roundBits == 7'h40) rounded[0] = 1'b0;
      if (rounded == '0) narrowRes = {nSign, 31'b0};
      else narrowRes = {nSign, 31'b0} + {1'b0, rExp[7:0], 23'b0} + {7'b0, rounded};
    end
  end

  // ---------------- widening path ----------------
  logic                 wSign;
  logic [NarExpW-1:0]   wExp;
  logic [NarFracW-1:0]  wFrac;
  logic [4:0]           lzCount;
  logic                 found;
  logic [4:0]           normShift;
  logic [23:0]          normSig;
  logic [WideW-1:0]     widenRes;

  always_comb begin
    wSign = dataIn[NarrowW-1];
    wExp  = dataIn[NarrowW-2 -: NarExpW];
    wFrac = dataIn[NarFracW-1:0];
    lzCount = '0;
    found = 1'b0;
    for (int i = NarFracW-1; i >= 0; i--) begin
      if (!found && wFrac[i]) begin
        lzCount = 5'(NarFracW-1-i);
        found = 1'b1;
      end
    end
    normShift = lzCount + 5'd1;
    normSig   = {1'b0, wFrac} << normShift;
    if (wExp == NarExpAll) begin
      if (wFrac != '0) widenRes = {wSign, WideExpAll, 1'b1, wFrac[21:0], {FracShift{1'b0}}};
      else             widenRes = {wSign, WideExpAll, {WideFracW{1'b0}}};
    end else if (wExp == '0) begin
      if (wFrac == '0) widenRes = {wSign, {(WideW-1){1'b0}}};
      else widenRes = {wSign, 11'h381 - {6'b0, normShift}, normSig[22:0], {FracShift{1'b0}}};
    end else begin
      widenRes = {wSign, {3'b000, wExp} + 11'h380, wFrac, {FracShift{1'b0}}};
    end
  end

  // ---------------- result register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataOut <= '0;
    else if (strobes.capture) dataOut <= opSel ? widenRes : {32'b0, narrowRes};
  end

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(dataOut));
  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !opSel) |=> (dataOut[63:32] == 32'b0));
  // R6
  narrow_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !opSel && dataIn[62:0] == 63'h7FF0_0000_0000_0000)
    |=> (dataOut[30:0] == 31'h7F80_0000 && dataOut[31] == $past(dataIn[63])));
  // R9
  widen_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && opSel && dataIn[30:23] == 8'hFF && dataIn[22:0] != 23'b0)
    |=> (dataOut[62:51] == 12'hFFF));
endmodule

// File: rtl/fpFormatConv.sv
module fpFormatConv
  import fpConvPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        opSel,
  input  logic [63:0] dataIn,
  output logic        outValid,
  output logic [63:0] dataOut
);
  ctrlStrobeT strobes;

  fpConvCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fpConvDatapath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opSel   (opSel),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/sim_fpFormatConv.sv
`timescale 1ns/1ps
module sim_fpFormatConv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        opSel = 1'b0;
  logic [63:0] dataIn = '0;
  logic        outValid;
  logic [63:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic        expValid = 1'b0;
  logic [63:0] expData = '0;
  string       curTag = "R2";

  always #10 clk = ~clk;

  fpFormatConv u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .dataIn(dataIn), .outValid(outValid), .dataOut(dataOut)
  );

  function automatic int msbPos(input logic [63:0] v);
    int p = -1;
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    return p;
  endfunction

  // integer significand model of binary64 -> binary32
  function automatic logic [31:0] refNarrow(input logic [63:0] d);
    logic s = d[63];
    int e = int'(d[62:52]);
    logic [63:0] m, r, rem, half;
    int q, p, qt, sh, be;
    if (e == 2047) begin
      if (d[51:0] != 0) return {s, 8'hFF, 1'b1, d[50:29]};
      return {s, 8'hFF, 23'b0};
    end
    if (e == 0 && d[51:0] == 0) return {s, 31'b0};
    m = (e != 0) ? {11'b0, 1'b1, d[51:0]} : {12'b0, d[51:0]};
    q = (e != 0) ? e - 1075 : -1074;
    p = msbPos(m);
    qt = q + p - 23;
    if (qt < -149) qt = -149;
    sh = qt - q;
    if (sh > 63) return {s, 31'b0};
    r = m >> sh;
    rem = m & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && r[0])) r = r + 64'd1;
    if (r == (64'd1 << 24)) begin r = 64'd1 << 23; qt = qt + 1; end
    if (r >= (64'd1 << 23)) begin
      be = qt + 150;
      if (be >= 255) return {s, 8'hFF, 23'b0};
      return {s, 8'(be), r[22:0]};
    end
    return {s, 8'h00, r[22:0]};
  endfunction

  function automatic logic [63:0] refWiden(input logic [31:0] w);
    logic s = w[31];
    int e8 = int'(w[30:23]);
    logic [22:0] f = w[22:0];
    logic [63:0] mant;
    int p, ex;
    if (e8 == 255) begin
      if (f != 0) return {s, 11'h7FF, 1'b1, f[21:0], 29'b0};
      return {s, 11'h7FF, 52'b0};
    end
    if (e8 == 0 && f == 0) return {s, 63'b0};
    if (e8 == 0) begin
      p = msbPos({41'b0, f});
      ex = p - 149 + 1023;
      mant = {41'b0, f} << (23 - p);
    end else begin
      ex = e8 - 127 + 1023;
      mant = {41'b0, f};
    end
    return {s, 11'(ex), mant[22:0], 29'b0};
  endfunction

  task automatic checkNow();
    checks++;
    if (outValid !== expValid) begin
      errors++;
      $display("FAIL R1 outValid actual %0b expected %0b", outValid, expValid);
    end
    checks++;
    if (dataOut !== expData) begin
      errors++;
      $display("FAIL %s dataOut actual %h expected %h (in %h)", curTag, dataOut, expData, dataIn);
    end
  endtask

  task automatic step(input logic v, input logic op, input logic [63:0] d,
                      input logic [63:0] exp, input string tag);
    @(negedge clk);
    checkNow();
    inValid = v; opSel = op; dataIn = d;
    expValid = v;
    if (v) begin expData = exp; curTag = tag; end
    else curTag = "R2";
  endtask

  task automatic narrow(input logic [63:0] d, input string tagIn);
    logic [31:0] r = refNarrow(d);
    string tag = tagIn;
    if (tag == "") begin
      if (d[62:52] == 11'h7FF) tag = "R6";
      else if (r[30:23] == 8'hFF) tag = "R4";
      else if (r[30:23] == 8'h00) tag = "R5";
      else tag = "R3";
    end
    step(1'b1, 1'b0, d, {32'b0, r}, tag);
  endtask

  task automatic widen(input logic [31:0] w);
    string tag;
    if (w[30:23] == 8'hFF || w[30:0] == 0) tag = "R9";
    else if (w[30:23] == 8'h00) tag = "R8";
    else tag = "R7";
    step(1'b1, 1'b1, {32'hA5A5_5A5A, w}, refWiden(w), tag);
  endtask

  task automatic expectDirect(input logic op, input logic [63:0] d,
                              input logic [63:0] exp, input string tag);
    step(1'b1, op, d, exp, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
    // reset state (R1, R2)
    repeat (3) @(negedge clk);
    checkNow();
    rstN = 1'b1;
    step(1'b0, 1'b0, '0, '0, "R2");

    // R3 directed rounding near 1.0
    expectDirect(1'b0, 64'h3FF0_0000_0000_0000, 64'h3F80_0000, "R3");
    expectDirect(1'b0, 64'h3FF0_0000_1000_0000, 64'h3F80_0000, "R3");
    expectDirect(1'b0, 64'h3FF0_0000_1000_0001, 64'h3F80_0001, "R3");
    expectDirect(1'b0, 64'h3FF0_0000_3000_0000, 64'h3F80_0002, "R3");
    // R4 overflow threshold
    expectDirect(1'b0, 64'h47EF_FFFF_E000_0000, 64'h7F7F_FFFF, "R4");
    expectDirect(1'b0, 64'h47EF_FFFF_EFFF_FFFF, 64'h7F7F_FFFF, "R4");
    expectDirect(1'b0, 64'h47EF_FFFF_F000_0000, 64'h7F80_0000, "R4");
    expectDirect(1'b0, 64'hC7EF_FFFF_F000_0000, 64'hFF80_0000, "R4");
    expectDirect(1'b0, 64'h7FEF_FFFF_FFFF_FFFF, 64'h7F80_0000, "R4");
    // R5 underflow
    expectDirect(1'b0, 64'h36A0_0000_0000_0000, 64'h0000_0001, "R5");
    expectDirect(1'b0, 64'h3690_0000_0000_0000, 64'h0000_0000, "R5");
    expectDirect(1'b0, 64'h3698_0000_0000_0000, 64'h0000_0001, "R5");
    expectDirect(1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000, "R5");
    expectDirect(1'b0, 64'h8000_0000_0000_0001, 64'h8000_0000, "R5");
    // R6 specials
    expectDirect(1'b0, 64'h7FF0_0000_0000_0001, 64'h7FC0_0000, "R6");
    expectDirect(1'b0, 64'hFFF8_0000_0000_0000, 64'hFFC0_0000, "R6");
    expectDirect(1'b0, 64'h7FF4_0000_0000_0000, 64'h7FE0_0000, "R6");
    expectDirect(1'b0, 64'hFFF0_0000_0000_0000, 64'hFF80_0000, "R6");
    // R2 hold over idle cycles
    step(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R2");
    step(1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, '0, "R2");
    // R7 R8 R9 widening
    expectDirect(1'b1, 64'h3F80_0000, 64'h3FF0_0000_0000_0000, "R7");
    expectDirect(1'b1, 64'h0000_0001, 64'h36A0_0000_0000_0000, "R8");
    expectDirect(1'b1, 64'h8000_0000, 64'h8000_0000_0000_0000, "R9");
    expectDirect(1'b1, 64'h7F80_0001, 64'h7FF8_0000_2000_0000, "R9");
    expectDirect(1'b1, 64'hFF80_0000, 64'hFFF0_0000_0000_0000, "R9");

    // pseudo-random narrowing, some steered to the underflow band
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      d = lfsr;
      if (i % 3 == 1) d[62:52] = 11'h350 + 11'(lfsr[5:0]);
      if (i % 7 == 3) d[62:52] = 11'h47E + 11'(lfsr[1:0]);
      narrow(d, "");
      if (i % 50 == 0) step(1'b0, 1'b0, ~d, '0, "R2");
    end

    // R10 round trip
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      w = lfsr[31:0];
      if (i % 4 == 0) w[30:23] = 8'h00;
      if (w[30:23] == 8'hFF && w[22:0] != 0) w[30] = 1'b0;
      widen(w);
      expectDirect(1'b0, refWiden(w), {32'b0, w}, "R10");
    end

    step(1'b0, 1'b0, '0, '0, "R2");
    step(1'b0, 1'b0, '0, '0, "R2");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule